// File: doc/BRIEF.md
# Infrared Pulse Run-Length Encoder

This block watches the single-bit output of a consumer-infrared receiver and describes it as a stream of run-length bytes. A divided sample tick is derived from the base clock, so each tick takes one sample. The raw line passes through a two-flop synchronizer and an optional polarity inversion before it is sampled.

Each emitted byte gives the level of a finished run and the number of samples the run lasted. Short level changes below a programmable noise threshold are absorbed into the run they interrupt. When the line has rested at space for a programmable number of 128-sample units, the block raises a packet-end pulse. It then stays silent until the next mark.

The bytes and the packet-end pulse feed a downstream buffer. That buffer, the register access and the interrupt logic are not part of this block.

Top module: `ir_rle_enc`

## Requirements
- R1: One sample is taken every SAMPLE_DIV base-clock cycles while the block is active. The raw line is synchronized through two flops before sampling. A level held for N×SAMPLE_DIV cycles counts as N samples.
- R2: Each output byte carries the run level in bit 7 (1 = mark, carrier present; 0 = space) and the run length minus one in bits 6:0. A finished run of L samples (1 ≤ L ≤ 128) yields one byte with bits 6:0 = L−1.
- R3: A run longer than 128 samples is sent as one byte of value {level, 7'h7F} for every full 128 samples, followed by a byte holding the remainder. A run that is an exact multiple of 128 yields only full-chunk bytes.
- R4: A level change is accepted only after it has lasted `noise_thr` consecutive samples (a value of 0 acts as 1). A shorter change is ignored, and its samples are added to the ongoing run.
- R5: `pkt_end` pulses for one cycle once a space run has lasted (`idle_thr`+1)×128 samples, counted from the first sample of that space. A full-chunk byte that completes on the same sample comes out in the same cycle. A leftover of less than 128 samples is dropped.
- R6: After packet end, and after the block is enabled, no byte is emitted until a mark is accepted. That mark's run counts from its first sample, and the preceding space is not reported.
- R7: With `inv_pol` = 1 the synchronized line is inverted before sampling, so a low raw line is a mark.
- R8: The block is active only while `glb_en` = 1, `rx_en` = 1 and `mode_sel` = 2'b11. Otherwise it emits nothing, and its run state returns to the idle-after-enable state.
- R9: While `rst_n` is low, `sym_valid` and `pkt_end` are 0 in the next cycle.
- R10: `sym_valid` and `pkt_end` are one-cycle strobes. Two consecutive bytes within a packet, where the first is not a full chunk, have opposite levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_in | input | 1 | Raw receiver line (asynchronous) |
| glb_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| mode_sel | input | 2 | Operating mode; 2'b11 selects infrared run-length capture |
| inv_pol | input | 1 | Invert the line before sampling |
| noise_thr | input | NTHR_W (6) | Minimum samples for an accepted level change |
| idle_thr | input | ITHR_W (8) | Idle limit in 128-sample units, minus one |
| sym_data | output | 8 | Run byte: level in bit 7, length−1 in bits 6:0 |
| sym_valid | output | 1 | One-cycle strobe for `sym_data` |
| pkt_end | output | 1 | One-cycle packet-end strobe |

## Verification
The bench builds the encoder with SAMPLE_DIV = 8 instead of 64. Every sample then costs eight cycles, so runs of several hundred samples fit easily in the run. This brings within reach runs that cross the 128-sample chunk boundary, and idle limits of one and two units (128 and 256 space samples). The other parameters keep their defaults, so the byte format, the 6-bit noise threshold and the 8-bit idle threshold are the production ones. Noise thresholds of 0, 1 and 3 cover the glitch merging both inside a packet and while idle.

// File: rtl/ir_rle_pkg.sv
// Shared constants and helpers for the infrared run-length encoder.
package ir_rle_pkg;
    localparam int          LEN_W    = 7;         // length field width of a run byte
    localparam int          SYM_W    = LEN_W + 1; // run byte width
    localparam logic [1:0]  MODE_CIR = 2'b11;     // mode value that enables capture

    // Build a run byte from a level and a length-minus-one field.
    function automatic logic [SYM_W-1:0] make_sym(input logic mark, input logic [LEN_W-1:0] len_m1);
        return {mark, len_m1};
    endfunction
endpackage

// File: rtl/ir_rle_tick.sv
// Sample-tick divider.
// Emits a one-cycle tick every DIV cycles while run is high. Assumes run low
// holds the phase at zero, so the first tick comes DIV cycles after run rises.
module ir_rle_tick #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            // Every active cycle is a sample.
            assign tick = run;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;

            // Free-running phase counter, cleared while inactive.
            always_ff @(posedge clk) begin
                if (!rst_n || !run)
                    cnt_q <= '0;
                else if (cnt_q == LAST)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end

            assign tick = run && (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/ir_rle_front.sv
// Input conditioning: two-flop synchronizer followed by polarity select.
// Assumes ir_raw is asynchronous to clk and that inv is quasi-static.
module ir_rle_front (
    input  logic clk,
    input  logic rst_n,
    input  logic ir_raw,
    input  logic inv,
    output logic lvl
);
    logic sync1_q, sync2_q;

    // Bring the raw line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= ir_raw;
            sync2_q <= sync1_q;
        end
    end

    assign lvl = sync2_q ^ inv;
endmodule

// File: rtl/ir_rle_idle.sv
// Idle-time counter for the current space run.
// Seeded with the length already seen when a space is accepted, then counts
// one per tick while count_en is high. at_limit flags the tick that completes
// (ithr+1) units of 2**UNIT_LOG2 samples. Assumes seed < 2**UNIT_LOG2.
module ir_rle_idle #(
    parameter int ITHR_W    = 8,
    parameter int UNIT_LOG2 = 7,
    parameter int SEED_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              seed_en,
    input  logic [SEED_W-1:0] seed,
    input  logic              count_en,
    input  logic [ITHR_W-1:0] ithr,
    output logic              at_limit
);
    localparam int CW = ITHR_W + 1 + UNIT_LOG2;

    logic [CW-1:0]       cnt_q;
    logic [ITHR_W:0]     units;
    logic [CW-1:0]       limit;
    logic [CW-1:0]       cnt_inc;

    assign units   = {1'b0, ithr} + {{ITHR_W{1'b0}}, 1'b1};
    assign limit   = {units, {UNIT_LOG2{1'b0}}};
    assign cnt_inc = cnt_q + {{(CW-1){1'b0}}, 1'b1};

    // Seed on a space acceptance, otherwise count space samples.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (tick) begin
            if (seed_en)
                cnt_q <= CW'(seed);
            else if (count_en)
                cnt_q <= cnt_inc;
        end
    end

    assign at_limit = count_en && (cnt_inc == limit);
endmodule

// File: rtl/ir_rle_track.sv
// Run tracker: deglitches sampled levels, measures runs, cuts them into
// run bytes and raises packet end. Acts only on tick cycles. Assumes the
// tick spacing is at least two cycles so strobes never last longer than one.
module ir_rle_track
    import ir_rle_pkg::*;
#(
    parameter int NTHR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              lvl,
    input  logic [NTHR_W-1:0] nthr,
    input  logic              idle_hit,
    output logic              space_cnt_en,
    output logic              seed_en,
    output logic [NTHR_W:0]   seed,
    output logic [SYM_W-1:0]  sym_data,
    output logic              sym_valid,
    output logic              pkt_end
);
    localparam int RUN_W = LEN_W + 1;
    localparam int SUM_W = ((NTHR_W > LEN_W) ? NTHR_W : LEN_W) + 2;
    localparam logic [SUM_W-1:0] CHUNK   = SUM_W'(2 ** LEN_W);
    localparam logic [LEN_W-1:0] ALL_ONE = '1;

    logic              cur_q, idle_q;
    logic [RUN_W-1:0]  len_q;
    logic [NTHR_W-1:0] cand_q;

    logic              cur_n, idle_n;
    logic [RUN_W-1:0]  len_n;
    logic [NTHR_W-1:0] cand_n;
    logic              emit, end_n;
    logic [SYM_W-1:0]  emit_d;

    logic [NTHR_W-1:0] nthr_eff;
    logic [NTHR_W:0]   cand_inc;
    logic [SUM_W-1:0]  sum;
    logic              differ, accept, expire;

    assign nthr_eff     = (nthr == '0) ? NTHR_W'(1) : nthr;
    assign cand_inc     = {1'b0, cand_q} + {{NTHR_W{1'b0}}, 1'b1};
    assign sum          = SUM_W'(len_q) + SUM_W'(cand_inc);
    assign differ       = (lvl != cur_q);
    assign accept       = tick && differ && (cand_inc >= {1'b0, nthr_eff});
    assign expire       = tick && !accept && idle_hit;
    assign space_cnt_en = !idle_q && !cur_q;
    assign seed_en      = accept && !lvl;
    assign seed         = cand_inc;

    // Next-state decision for one sample.
    always_comb begin
        cur_n  = cur_q;
        idle_n = idle_q;
        len_n  = len_q;
        cand_n = cand_q;
        emit   = 1'b0;
        emit_d = '0;
        end_n  = 1'b0;
        if (tick) begin
            if (!differ) begin
                cand_n = '0;
                if (!idle_q) begin
                    if (sum >= CHUNK) begin
                        emit   = 1'b1;
                        emit_d = make_sym(cur_q, ALL_ONE);
                        len_n  = RUN_W'(sum - CHUNK);
                    end else begin
                        len_n  = RUN_W'(sum);
                    end
                end
            end else if (accept) begin
                if (!idle_q && (len_q != '0)) begin
                    emit   = 1'b1;
                    emit_d = make_sym(cur_q, LEN_W'(len_q - 1'b1));
                end
                cur_n  = lvl;
                idle_n = 1'b0;
                len_n  = RUN_W'(cand_inc);
                cand_n = '0;
            end else begin
                cand_n = cand_q + 1'b1;
            end
            if (expire) begin
                end_n  = 1'b1;
                idle_n = 1'b1;
                len_n  = '0;
                cand_n = '0;
            end
        end
    end

    // Run state and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cur_q     <= 1'b0;
            idle_q    <= 1'b1;
            len_q     <= '0;
            cand_q    <= '0;
            sym_valid <= 1'b0;
            sym_data  <= '0;
            pkt_end   <= 1'b0;
        end else begin
            cur_q     <= cur_n;
            idle_q    <= idle_n;
            len_q     <= len_n;
            cand_q    <= cand_n;
            sym_valid <= emit;
            pkt_end   <= end_n;
            if (emit)
                sym_data <= emit_d;
        end
    end
endmodule

// File: rtl/ir_rle_enc.sv
// Infrared pulse run-length encoder, top level.
// Ties the input conditioner, sample divider, run tracker and idle counter
// together. Assumes thresholds and polarity change only while inactive.
module ir_rle_enc
    import ir_rle_pkg::*;
#(
    parameter int SAMPLE_DIV = 64,
    parameter int NTHR_W     = 6,
    parameter int ITHR_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_in,
    input  logic              glb_en,
    input  logic              rx_en,
    input  logic [1:0]        mode_sel,
    input  logic              inv_pol,
    input  logic [NTHR_W-1:0] noise_thr,
    input  logic [ITHR_W-1:0] idle_thr,
    output logic [7:0]        sym_data,
    output logic              sym_valid,
    output logic              pkt_end
);
    logic            active, tick, lvl;
    logic            space_cnt_en, seed_en, idle_hit;
    logic [NTHR_W:0] seed;

    assign active = glb_en && rx_en && (mode_sel == MODE_CIR);

    ir_rle_front u_front (
        .clk    (clk),
        .rst_n  (rst_n),
        .ir_raw (ir_in),
        .inv    (inv_pol),
        .lvl    (lvl)
    );

    ir_rle_tick #(.DIV(SAMPLE_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (active),
        .tick  (tick)
    );

    ir_rle_track #(.NTHR_W(NTHR_W)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (active),
        .tick         (tick),
        .lvl          (lvl),
        .nthr         (noise_thr),
        .idle_hit     (idle_hit),
        .space_cnt_en (space_cnt_en),
        .seed_en      (seed_en),
        .seed         (seed),
        .sym_data     (sym_data),
        .sym_valid    (sym_valid),
        .pkt_end      (pkt_end)
    );

    ir_rle_idle #(
        .ITHR_W    (ITHR_W),
        .UNIT_LOG2 (LEN_W),
        .SEED_W    (NTHR_W + 1)
    ) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (active),
        .tick     (tick),
        .seed_en  (seed_en),
        .seed     (seed),
        .count_en (space_cnt_en),
        .ithr     (idle_thr),
        .at_limit (idle_hit)
    );
endmodule

// File: rtl/ir_rle_enc_chk.sv
// Protocol checker for ir_rle_enc, attached by bind. Observes ports only.
module ir_rle_enc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       glb_en,
    input logic       rx_en,
    input logic [1:0] mode_sel,
    input logic [7:0] sym_data,
    input logic       sym_valid,
    input logic       pkt_end
);
    logic       rst_seen_q;
    logic       have_prev_q;
    logic [7:0] prev_q;
    logic       on;

    assign on = glb_en && rx_en && (mode_sel == 2'b11);

    // Remember that reset was low in the previous cycle.
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // Keep the last byte of the current packet.
    always_ff @(posedge clk) begin
        if (!rst_n || !on || pkt_end)
            have_prev_q <= 1'b0;
        else if (sym_valid)
            have_prev_q <= 1'b1;
        if (sym_valid)
            prev_q <= sym_data;
    end

    // R9: outputs quiet after a reset cycle.
    always @(posedge clk) begin
        if (rst_seen_q === 1'b1)
            a_r9_reset_quiet: assert (!sym_valid && !pkt_end);
    end

    // R10: a byte after a partial run byte flips level.
    always @(posedge clk) begin
        if (rst_n && sym_valid && have_prev_q && (prev_q[6:0] != 7'h7F))
            a_r10_alternate: assert (sym_data[7] != prev_q[7]);
    end

    a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !on |=> (!sym_valid && !pkt_end));

    a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> !sym_valid);

    a_r5_end_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> !pkt_end);

    a_r6_no_byte_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> !sym_valid);
endmodule

bind ir_rle_enc ir_rle_enc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .glb_en    (glb_en),
    .rx_en     (rx_en),
    .mode_sel  (mode_sel),
    .sym_data  (sym_data),
    .sym_valid (sym_valid),
    .pkt_end   (pkt_end)
);

// File: tb/ir_rle_enc_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: scenario tasks queue expected bytes and packet ends,
// a negedge monitor pops and compares them as the design produces them.
module ir_rle_enc_tb;
    localparam int DIV = 8;
    localparam logic [8:0] PKT = 9'h100;

    typedef struct {
        logic [8:0] val;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_in = 1'b0;
    logic       glb_en = 1'b0;
    logic       rx_en = 1'b1;
    logic [1:0] mode_sel = 2'b11;
    logic       inv_pol = 1'b0;
    logic [5:0] noise_thr = 6'd1;
    logic [7:0] idle_thr = 8'd0;
    logic [7:0] sym_data;
    logic       sym_valid;
    logic       pkt_end;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R8";
    exp_t  q[$];

    always #4 clk = ~clk;

    ir_rle_enc #(.SAMPLE_DIV(DIV)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ir_in     (ir_in),
        .glb_en    (glb_en),
        .rx_en     (rx_en),
        .mode_sel  (mode_sel),
        .inv_pol   (inv_pol),
        .noise_thr (noise_thr),
        .idle_thr  (idle_thr),
        .sym_data  (sym_data),
        .sym_valid (sym_valid),
        .pkt_end   (pkt_end)
    );

    // Compare one observed item against the queue head.
    task automatic observe(input logic [8:0] got);
        exp_t e;
        checks++;
        if (q.size() == 0) begin
            errors++;
            $display("FAIL %s unexpected output actual=%h expected=none", cur_req, got);
        end else begin
            e = q.pop_front();
            if (e.val !== got) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", e.req, got, e.val);
            end
        end
    endtask

    // Monitor: byte first, then packet end of the same cycle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sym_valid) observe({1'b0, sym_data});
            if (pkt_end)   observe(PKT);
        end
    end

    task automatic push(input logic [8:0] v, input string r);
        exp_t e;
        e.val = v;
        e.req = r;
        q.push_back(e);
    endtask

    // Expected bytes for a run of n samples that is ended by a level change.
    task automatic exp_run(input logic m, input int n, input string r);
        int rem = n;
        while (rem > 128) begin
            push({1'b0, m, 7'h7F}, r);
            rem -= 128;
        end
        push({1'b0, m, 7'(rem - 1)}, r);
    endtask

    // Drive a raw level for n samples.
    task automatic hold(input logic v, input int n);
        ir_in = v;
        repeat (n * DIV) @(negedge clk);
    endtask

    // Restart the block with new settings and a given idle raw level.
    task automatic start(input logic [5:0] nt, input logic [7:0] it,
                         input logic inv, input logic idle_raw);
        @(negedge clk);
        glb_en = 1'b0;
        noise_thr = nt;
        idle_thr = it;
        inv_pol = inv;
        ir_in = idle_raw;
        repeat (4) @(negedge clk);
        glb_en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Let outputs settle, then require an empty scoreboard.
    task automatic drain(input string r);
        repeat (4 * DIV) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL %s missing outputs actual=%0d left expected=0", r, q.size());
            q.delete();
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        // R9: reset state.
        repeat (3) @(negedge clk);
        checks++;
        if (sym_valid !== 1'b0 || pkt_end !== 1'b0) begin
            errors++;
            $display("FAIL R9 actual=%b%b expected=00", sym_valid, pkt_end);
        end
        rst_n = 1'b1;

        // R1 R2 R3 R5 R6: basic runs, chunking, packet end at 128 space samples.
        cur_req = "R6";
        start(6'd1, 8'd0, 1'b0, 1'b0);
        exp_run(1'b1, 5, "R2");
        exp_run(1'b0, 3, "R1");
        exp_run(1'b1, 200, "R3");
        push({1'b0, 1'b0, 7'h7F}, "R5");
        push(PKT, "R5");
        hold(1'b0, 10); hold(1'b1, 5); hold(1'b0, 3); hold(1'b1, 200);
        hold(1'b0, 150);
        // R6: restart counts from one after packet end.
        exp_run(1'b1, 4, "R6");
        push({1'b0, 1'b0, 7'h7F}, "R6");
        push(PKT, "R6");
        hold(1'b1, 4); hold(1'b0, 140);
        drain("R6");

        // R4: noise threshold 3, glitches merged in packet and ignored while idle.
        cur_req = "R4";
        start(6'd3, 8'd0, 1'b0, 1'b0);
        push({1'b0, 1'b1, 7'd11}, "R4");
        push({1'b0, 1'b0, 7'h7F}, "R4");
        push(PKT, "R4");
        hold(1'b1, 6); hold(1'b0, 2); hold(1'b1, 4); hold(1'b0, 140);
        push({1'b0, 1'b1, 7'd4}, "R4");
        push({1'b0, 1'b0, 7'h7F}, "R4");
        push(PKT, "R4");
        hold(1'b1, 1); hold(1'b0, 5);
        hold(1'b1, 5); hold(1'b0, 10); hold(1'b1, 1); hold(1'b0, 150);
        drain("R4");

        // R4: zero threshold behaves as one.
        start(6'd0, 8'd0, 1'b0, 1'b0);
        push({1'b0, 1'b1, 7'd1}, "R4");
        push({1'b0, 1'b0, 7'h7F}, "R4");
        push(PKT, "R4");
        hold(1'b1, 2); hold(1'b0, 135);
        drain("R4");

        // R7: inverted polarity, raw low is mark.
        cur_req = "R7";
        start(6'd1, 8'd0, 1'b1, 1'b1);
        push({1'b0, 1'b1, 7'd6}, "R7");
        push({1'b0, 1'b0, 7'h7F}, "R7");
        push(PKT, "R7");
        hold(1'b1, 5); hold(1'b0, 7); hold(1'b1, 140);
        drain("R7");

        // R5: idle limit of two units, space of 255 does not end the packet.
        cur_req = "R5";
        start(6'd1, 8'd1, 1'b0, 1'b0);
        exp_run(1'b1, 3, "R5");
        exp_run(1'b0, 255, "R5");
        exp_run(1'b1, 2, "R5");
        push({1'b0, 1'b0, 7'h7F}, "R5");
        push({1'b0, 1'b0, 7'h7F}, "R5");
        push(PKT, "R5");
        hold(1'b1, 3); hold(1'b0, 255); hold(1'b1, 2); hold(1'b0, 270);
        drain("R5");

        // R3: exact 128 mark gives one chunk only; 129 gives chunk plus one.
        cur_req = "R3";
        start(6'd1, 8'd0, 1'b0, 1'b0);
        push({1'b0, 1'b1, 7'h7F}, "R3");
        push({1'b0, 1'b0, 7'h7F}, "R3");
        push(PKT, "R3");
        hold(1'b1, 128); hold(1'b0, 135);
        exp_run(1'b1, 129, "R3");
        push({1'b0, 1'b0, 7'h7F}, "R3");
        push(PKT, "R3");
        hold(1'b1, 129); hold(1'b0, 135);
        drain("R3");

        // R8: wrong mode and receive disable give no output.
        cur_req = "R8";
        start(6'd1, 8'd0, 1'b0, 1'b0);
        mode_sel = 2'b01;
        hold(1'b1, 10); hold(1'b0, 200);
        mode_sel = 2'b11;
        rx_en = 1'b0;
        hold(1'b1, 10); hold(1'b0, 200);
        drain("R8");
        rx_en = 1'b1;
        start(6'd1, 8'd0, 1'b0, 1'b0);
        push({1'b0, 1'b1, 7'd2}, "R8");
        push({1'b0, 1'b0, 7'h7F}, "R8");
        push(PKT, "R8");
        hold(1'b1, 3); hold(1'b0, 140);
        drain("R8");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule